// File: doc/BRIEF.md
# Oscillator Source Switching Controller

This block decides which of three oscillator sources clocks the system: a primary oscillator, an internal RC oscillator and a low-power secondary oscillator. Each source comes in as a tick input. The block samples every tick input in a single reference clock domain. Each input passes through a two-flop synchroniser and a rising-edge detector. Software writes a 2-bit select value. The controller counts the cycles that the requested source needs. Only when the count completes does it hand the system over to that source, and it then updates three status flags.

A crystal-type primary needs a long start-up timer followed by a short settle count. During the start-up timer the previously active source keeps clocking the system. After reset no switch sequence runs. The controller counts the primary start-up timer directly, and execution is either held or carried by the internal RC source, depending on the two-speed option.

The controller has four states:
- `ST_BOOT`: reset start-up.
- `ST_RUN`: steady operation.
- `ST_STARTUP`: the start-up timer of a switch is running.
- `ST_SETTLE`: the settle count is running.

It has these transitions:
- BOOT→RUN, when the timer expires or the primary is a non-crystal source.
- RUN→STARTUP, on a request for a crystal primary.
- RUN→SETTLE, on any other accepted request.
- STARTUP→SETTLE, when the timer expires.
- SETTLE→RUN, on handover.
- STARTUP/SETTLE→RUN, when a request cancels the switch.
- STARTUP/SETTLE→STARTUP/SETTLE, when a request retargets the switch.

Top module: `osc_switch_ctrl`

## Requirements
- R1: The select input encodes 2'b00 as primary, 2'b01 as secondary and 2'b10 as internal RC. The value 2'b11 is ignored. A completed switch drives `active_src` to the code of the requested source. `active_src` = 2'b11 means execution is held.
- R2: A switch to the internal RC source, to the secondary source, or to a non-crystal primary hands over on the SETTLE_CYC-th (8th) tick of the target source. Earlier ticks leave `active_src` unchanged.
- R3: A switch to a crystal primary (`pri_xtal`=1) first counts OST_CYC (1024) primary ticks and then SETTLE_CYC more primary ticks before the handover.
- R4: While a switch is pending, `active_src` keeps showing the old source and `run_en` stays 1.
- R5: A secondary request while `sec_en`=0 is ignored. `active_src`, `sec_run`, `ost_done` and `int_stable` all keep their values.
- R6: When a switch to the secondary source completes, `sec_run`=1 and `ost_done`=0. When a switch to the primary completes, `ost_done`=1 and `sec_run`=0. When a switch to the internal RC source completes, both flags are 0.
- R7: `int_stable` is 0 while the internal RC source is not active. It rises IOFS_CYC reference cycles after the internal RC source becomes active.
- R8: After reset with a crystal primary and `two_speed`=0, `run_en`=0 and `active_src`=2'b11 until OST_CYC primary ticks have been counted. The primary then becomes active with `ost_done`=1.
- R9: After reset with a crystal primary and `two_speed`=1, `active_src` shows the internal RC source and `run_en`=1 until the timer expires. The primary then takes over.
- R10: A different valid select value during a pending switch restarts the count for the new target. If that value equals the active source, the pending switch is cancelled.
- R11: `active_src` changes only at the completion of a count, never partway through one.
- R12: After reset with a non-crystal primary (`pri_xtal`=0), the primary becomes active without the start-up timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_tick | input | 1 | Primary oscillator tick (asynchronous) |
| sec_tick | input | 1 | Secondary oscillator tick (asynchronous) |
| int_tick | input | 1 | Internal RC oscillator tick (asynchronous) |
| sel | input | 2 | Requested source code |
| pri_xtal | input | 1 | 1 = primary is a crystal type, 0 = external clock or RC |
| sec_en | input | 1 | Secondary oscillator enable |
| two_speed | input | 1 | Internal RC carries the system during reset start-up |
| active_src | output | 2 | Source currently clocking the system (2'b11 = held) |
| run_en | output | 1 | Execution enabled |
| sec_run | output | 1 | Secondary source is running the system |
| ost_done | output | 1 | Primary start-up timer completed and primary active |
| int_stable | output | 1 | Internal RC source has been active for IOFS_CYC cycles |

## Verification
The assertions check these behaviours on every cycle:
- `run_en` stays high while a switch is pending.
- `active_src` moves only on leaving the settle state.
- The two run flags are never set together.
- `sec_run` and `int_stable` each agree with the active source.
- A gated secondary request never starts a switch.

Only the directed scenarios can show the exact tick counts of the 8-tick and 1024+8-tick handovers. The same holds for the restart of a retargeted count, the reset start-up variants and the delayed rise of `int_stable`.

// File: rtl/osw_pkg.sv
package osw_pkg;

    typedef enum logic [1:0] {
        SRC_PRI  = 2'b00,
        SRC_SEC  = 2'b01,
        SRC_INT  = 2'b10,
        SRC_HELD = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_STARTUP = 2'd2,
        ST_SETTLE  = 2'd3
    } sw_state_e;

    localparam int NUM_SRC = 3;

endpackage

// File: rtl/osw_tick_sync.sv
module osw_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // one reference-cycle pulse per rising edge of the synchronised tick
    assign pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/osw_cycle_counter.sv
module osw_cycle_counter #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/osw_stable_timer.sv
module osw_stable_timer #(
    parameter int LIMIT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LIM);
endmodule

// File: rtl/osc_switch_ctrl.sv
module osc_switch_ctrl
    import osw_pkg::*;
#(
    parameter int OST_CYC    = 1024,
    parameter int SETTLE_CYC = 8,
    parameter int IOFS_CYC   = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_tick,
    input  logic       sec_tick,
    input  logic       int_tick,
    input  logic [1:0] sel,
    input  logic       pri_xtal,
    input  logic       sec_en,
    input  logic       two_speed,
    output logic [1:0] active_src,
    output logic       run_en,
    output logic       sec_run,
    output logic       ost_done,
    output logic       int_stable
);
    localparam int MAX_CYC = (OST_CYC > SETTLE_CYC) ? OST_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] OST_LAST    = CNT_W'(OST_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    // tick synchronisers: index 0 primary, 1 secondary, 2 internal RC
    logic [NUM_SRC-1:0] tick_raw;
    logic [NUM_SRC-1:0] tick_p;
    assign tick_raw = {int_tick, sec_tick, pri_tick};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
        osw_tick_sync #(.STAGES(2)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_in (tick_raw[i]),
            .pulse   (tick_p[i])
        );
    end

    sw_state_e       state_q, state_d;
    src_e            active_q, active_d;
    src_e            target_q, target_d;
    logic            sec_run_q, sec_run_d;
    logic            ost_done_q, ost_done_d;
    logic            cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;
    logic            tgt_tick;
    logic            req_ok;
    src_e            req_src;

    osw_cycle_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    assign req_src = src_e'(sel);
    assign req_ok  = (req_src == SRC_PRI) || (req_src == SRC_INT) ||
                     ((req_src == SRC_SEC) && sec_en);

    always_comb begin
        unique case (target_q)
            SRC_PRI: tgt_tick = tick_p[0];
            SRC_SEC: tgt_tick = tick_p[1];
            SRC_INT: tgt_tick = tick_p[2];
            default: tgt_tick = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_BOOT;
            active_q   <= SRC_HELD;
            target_q   <= SRC_PRI;
            sec_run_q  <= 1'b0;
            ost_done_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            active_q   <= active_d;
            target_q   <= target_d;
            sec_run_q  <= sec_run_d;
            ost_done_q <= ost_done_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        active_d   = active_q;
        target_d   = target_q;
        sec_run_d  = sec_run_q;
        ost_done_d = ost_done_q;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                if (!pri_xtal) begin
                    state_d    = ST_RUN;
                    active_d   = SRC_PRI;
                    target_d   = SRC_PRI;
                    ost_done_d = 1'b1;
                    cnt_clr    = 1'b1;
                end else if (tick_p[0]) begin
                    if (cnt == OST_LAST) begin
                        state_d    = ST_RUN;
                        active_d   = SRC_PRI;
                        target_d   = SRC_PRI;
                        ost_done_d = 1'b1;
                        cnt_clr    = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (req_ok && (req_src != active_q)) begin
                    target_d = req_src;
                    cnt_clr  = 1'b1;
                    state_d  = ((req_src == SRC_PRI) && pri_xtal) ? ST_STARTUP : ST_SETTLE;
                end
            end
            ST_STARTUP, ST_SETTLE: begin
                if (req_ok && (req_src != target_q)) begin
                    cnt_clr  = 1'b1;
                    target_d = req_src;
                    if (req_src == active_q)
                        state_d = ST_RUN;
                    else
                        state_d = ((req_src == SRC_PRI) && pri_xtal) ? ST_STARTUP : ST_SETTLE;
                end else if (state_q == ST_STARTUP) begin
                    if (tick_p[0]) begin
                        if (cnt == OST_LAST) begin
                            cnt_clr = 1'b1;
                            state_d = ST_SETTLE;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end else if (tgt_tick) begin
                    if (cnt == SETTLE_LAST) begin
                        active_d   = target_q;
                        sec_run_d  = (target_q == SRC_SEC);
                        ost_done_d = (target_q == SRC_PRI);
                        cnt_clr    = 1'b1;
                        state_d    = ST_RUN;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs
    logic [1:0] active_o;
    logic       run_o;
    always_comb begin
        if (state_q == ST_BOOT) begin
            active_o = two_speed ? SRC_INT : SRC_HELD;
            run_o    = two_speed;
        end else begin
            active_o = active_q;
            run_o    = 1'b1;
        end
    end

    assign active_src = active_o;
    assign run_en     = run_o;
    assign sec_run    = sec_run_q;
    assign ost_done   = ost_done_q;

    osw_stable_timer #(.LIMIT(IOFS_CYC)) u_iofs (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active_o == SRC_INT),
        .done  (int_stable)
    );
endmodule

// File: rtl/osc_switch_ctrl_sva.sv
module osc_switch_ctrl_sva
    import osw_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int SETTLE_CYC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel,
    input logic             sec_en,
    input logic [1:0]       active_src,
    input logic             run_en,
    input logic             sec_run,
    input logic             ost_done,
    input logic             int_stable,
    input sw_state_e        state_q,
    input logic [CNT_W-1:0] cnt
);
    p_run_while_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP || state_q == ST_SETTLE) |-> run_en);

    p_change_only_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(active_src) && $past(state_q) != ST_BOOT) |-> ($past(state_q) == ST_SETTLE));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_run && ost_done));

    p_sec_flag_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_run |-> (active_src == SRC_SEC));

    p_stable_only_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_stable |-> (active_src == SRC_INT));

    p_gated_sec_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sel == SRC_SEC && !sec_en && active_src != SRC_SEC)
        |=> (state_q == ST_RUN));

    p_settle_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (cnt < CNT_W'(SETTLE_CYC)));

    p_held_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (active_src == SRC_HELD));
endmodule

bind osc_switch_ctrl osc_switch_ctrl_sva #(
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .sec_en     (sec_en),
    .active_src (active_src),
    .run_en     (run_en),
    .sec_run    (sec_run),
    .ost_done   (ost_done),
    .int_stable (int_stable),
    .state_q    (state_q),
    .cnt        (cnt)
);

// File: tb/osc_switch_ctrl_tb.sv
module osc_switch_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OST        = 1024;
    localparam int SET        = 8;
    localparam int IOFS       = 4000;
    localparam logic [1:0] C_PRI = 2'b00, C_SEC = 2'b01, C_INT = 2'b10, C_HELD = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_tick = 1'b0, sec_tick = 1'b0, int_tick = 1'b0;
    logic [1:0] sel = 2'b00;
    logic pri_xtal = 1'b1, sec_en = 1'b0, two_speed = 1'b0;
    logic [1:0] active_src;
    logic run_en, sec_run, ost_done, int_stable;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_switch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .pri_tick(pri_tick), .sec_tick(sec_tick), .int_tick(int_tick),
        .sel(sel), .pri_xtal(pri_xtal), .sec_en(sec_en), .two_speed(two_speed),
        .active_src(active_src), .run_en(run_en), .sec_run(sec_run),
        .ost_done(ost_done), .int_stable(int_stable)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // which: 0 primary, 1 secondary, 2 internal RC
    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            case (which)
                0: pri_tick = 1'b1;
                1: sec_tick = 1'b1;
                default: int_tick = 1'b1;
            endcase
            wait_clk(3);
            pri_tick = 1'b0; sec_tick = 1'b0; int_tick = 1'b0;
            wait_clk(3);
        end
    endtask

    task automatic do_reset(input logic xtal, input logic ts);
        rst_n = 1'b0; pri_xtal = xtal; two_speed = ts; sel = C_PRI; sec_en = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic t_boot_held;
        do_reset(1'b1, 1'b0);
        check("R8 held active_src", active_src, C_HELD);
        check("R8 run_en low", run_en, 0);
        pulse(0, OST - 1);
        check("R8 still held before timer end", run_en, 0);
        pulse(0, 1);
        check("R8 primary after timer", active_src, C_PRI);
        check("R8 run_en after timer", run_en, 1);
        check("R6 ost_done after boot", ost_done, 1);
    endtask

    task automatic t_to_int;
        sel = C_INT; wait_clk(2);
        pulse(2, SET - 1);
        check("R2 int not yet active after 7 ticks", active_src, C_PRI);
        check("R4 run_en while pending", run_en, 1);
        pulse(2, 1);
        check("R1 int active after 8 ticks", active_src, C_INT);
        check("R6 int ost_done", ost_done, 0);
        check("R6 int sec_run", sec_run, 0);
        check("R7 int_stable low at handover", int_stable, 0);
        wait_clk(IOFS - 10);
        check("R7 int_stable low before delay", int_stable, 0);
        wait_clk(20);
        check("R7 int_stable high after delay", int_stable, 1);
    endtask

    task automatic t_sec_gated;
        sec_en = 1'b0; sel = C_SEC; wait_clk(2);
        pulse(1, SET + 2);
        check("R5 gated sec active_src", active_src, C_INT);
        check("R5 gated sec sec_run", sec_run, 0);
        check("R5 gated sec int_stable", int_stable, 1);
        check("R5 gated sec ost_done", ost_done, 0);
    endtask

    task automatic t_to_sec;
        sec_en = 1'b1; wait_clk(2);
        pulse(1, SET - 1);
        check("R2 sec not yet active", active_src, C_INT);
        pulse(1, 1);
        check("R1 sec active", active_src, C_SEC);
        check("R6 sec_run set", sec_run, 1);
        check("R6 ost_done clear on sec", ost_done, 0);
        check("R7 int_stable cleared", int_stable, 0);
    endtask

    task automatic t_to_xtal;
        sel = C_PRI; wait_clk(2);
        pulse(0, OST);
        check("R4 old source during startup", active_src, C_SEC);
        check("R4 run_en during startup", run_en, 1);
        pulse(0, SET - 1);
        check("R3 not active before settle end", active_src, C_SEC);
        pulse(0, 1);
        check("R3 crystal primary active", active_src, C_PRI);
        check("R6 ost_done on primary", ost_done, 1);
        check("R6 sec_run clear on primary", sec_run, 0);
    endtask

    task automatic t_retarget;
        sel = C_INT; wait_clk(2);
        pulse(2, 5);
        sel = C_SEC; wait_clk(2);
        pulse(1, SET - 1);
        check("R10 retarget restarted count", active_src, C_PRI);
        pulse(1, 1);
        check("R10 retarget reached sec", active_src, C_SEC);
        sel = C_INT; wait_clk(2);
        pulse(2, 3);
        sel = C_SEC; wait_clk(2);
        pulse(2, SET + 2);
        check("R10 cancel keeps sec", active_src, C_SEC);
        check("R11 sec_run unchanged by cancel", sec_run, 1);
    endtask

    task automatic t_ext_primary;
        pri_xtal = 1'b0; sel = C_PRI; wait_clk(2);
        pulse(0, SET - 1);
        check("R2 ext primary not yet", active_src, C_SEC);
        pulse(0, 1);
        check("R2 ext primary active after 8", active_src, C_PRI);
        check("R6 ext primary ost_done", ost_done, 1);
    endtask

    task automatic t_two_speed;
        do_reset(1'b1, 1'b1);
        check("R9 int carries boot", active_src, C_INT);
        check("R9 run_en during boot", run_en, 1);
        pulse(0, OST - 1);
        check("R9 still int before timer end", active_src, C_INT);
        pulse(0, 1);
        check("R9 primary after timer", active_src, C_PRI);
        check("R9 int_stable clear after", int_stable, 0);
    endtask

    task automatic t_ext_boot;
        do_reset(1'b0, 1'b0);
        check("R12 ext primary immediate", active_src, C_PRI);
        check("R12 run_en immediate", run_en, 1);
        sel = 2'b11; wait_clk(2);
        pulse(0, SET + 2); pulse(1, SET + 2); pulse(2, SET + 2);
        check("R1 code 11 ignored", active_src, C_PRI);
    endtask

    initial begin
        t_boot_held();
        t_to_int();
        t_sec_gated();
        t_to_sec();
        t_to_xtal();
        t_retarget();
        t_ext_primary();
        t_two_speed();
        t_ext_boot();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule